// File: doc/BRIEF.md
# Byte-Lane Data Bus Inversion Codec

This block sits between a memory controller's data path and the physical data lines of a 16-bit channel that is split into two byte lanes. Each lane has one shared flag line. On the transmit side the block looks at each byte and decides whether to send it complemented. It raises the lane's flag line whenever it does, so that the lines that are driven high stay few. This lowers power because the lines are terminated low. On the receive side it undoes the complement for every lane whose flag arrived high.

The flag line also carries the write byte mask. When write inversion is off, a masked byte raises the flag to mean "leave this byte unwritten". When write inversion is on, the line cannot carry both meanings. In that case the block sends the masked byte without inversion and raises a per-lane error bit to the requester. Read and write inversion have separate enables. Both paths are registered, take one cycle and accept a new beat on every cycle.

Top module: `lane_inv_codec`

## Requirements
- R1: While reset is high and on the first cycle after it, every output is zero: the valid outputs, the bus data, the flags, the error bits and the restored data.
- R2: With write inversion enabled and a lane unmasked, a byte with five or more ones is sent complemented with its flag high. A byte with four or fewer ones is sent unchanged with its flag low. A flag that is high therefore never comes with more than three data lines high.
- R3: Lane k covers data bits [8k+7:8k] and flag bit k (lane 0 is bits 7:0). Each lane's choice depends only on its own byte and its own mask bit.
- R4: With write inversion disabled, an unmasked byte is sent unchanged with its flag low.
- R5: With write inversion disabled, a masked lane (mask bit 1 = do not write) is sent with its flag high and its data unchanged.
- R6: With write inversion enabled, a masked lane is sent unchanged with its flag low, and that lane's error bit goes high. Error bits are low in every other case.
- R7: Each accepted beat (valid high at a clock edge) appears on the outputs after exactly one cycle, and beats may arrive on consecutive cycles. When no beat was accepted, the valid output is low and the data, flag and error outputs are zero.
- R8: With read inversion enabled, a received byte whose flag is high is restored complemented, and one whose flag is low is restored unchanged.
- R9: With read inversion disabled, received flags have no effect and bytes pass through unchanged.
- R10: The two inversion enables are independent: the read enable does not change transmit results, and the write enable does not change receive results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_inv_en | input | 1 | Enables inversion on the transmit (write) path |
| rd_inv_en | input | 1 | Enables inversion on the receive (read) path |
| tx_valid | input | 1 | Transmit beat present |
| tx_data | input | 16 | Transmit bytes, lane 0 in bits 7:0 |
| tx_mask | input | 2 | Per-lane write mask, 1 = do not write |
| tx_bus_valid | output | 1 | Transmit beat on the bus |
| tx_bus_data | output | 16 | Encoded data lines |
| tx_bus_flag | output | 2 | Per-lane shared inversion/mask line |
| tx_mask_err | output | 2 | Per-lane flag: masked beat with write inversion on |
| rx_valid | input | 1 | Receive beat present |
| rx_bus_data | input | 16 | Received data lines |
| rx_bus_flag | input | 2 | Received per-lane inversion line |
| rx_out_valid | output | 1 | Restored beat present |
| rx_out_data | output | 16 | Restored bytes |

## Verification
The transmit path is driven with bytes of exactly four and exactly five ones, which brackets the inversion threshold, and with all-zero and all-one bytes. It also gets lanes that differ within one beat, to show that the two lanes decide independently. Each byte is sent under all four combinations of mask and write enable, which separates the mask meaning of the flag from its inversion meaning and the error case. The receive path is driven with every flag pattern under both read-enable values. Long runs of back-to-back random beats in both directions exercise the one-cycle latency and the independence of the two enables.

// File: rtl/lane_inv_pkg.sv
package lane_inv_pkg;

  // Number of ones in the low "width" bits of a value.
  function automatic int unsigned ones_in(input logic [63:0] v, input int unsigned width);
    int unsigned n;
    n = 0;
    for (int unsigned i = 0; i < width; i++) begin
      n += int'(v[i]);
    end
    return n;
  endfunction

  // True when sending the byte complemented drives fewer lines high.
  function automatic logic wants_invert(input logic [63:0] v, input int unsigned width);
    return (2 * ones_in(v, width)) > width;
  endfunction

endpackage

// File: rtl/lane_inv_enc.sv
module lane_inv_enc #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         inv_en,
  input  logic         mask,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         flag,
  output logic         err
);
  import lane_inv_pkg::*;

  logic         heavy;
  logic [W-1:0] nxt_data;
  logic         nxt_flag;
  logic         nxt_err;

  always_comb begin
    heavy    = wants_invert(64'(din), W);
    nxt_data = din;
    nxt_flag = 1'b0;
    nxt_err  = 1'b0;
    if (!inv_en) begin
      nxt_flag = mask;
    end else if (mask) begin
      nxt_err = 1'b1;
    end else if (heavy) begin
      nxt_data = ~din;
      nxt_flag = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !in_valid) begin
      dout <= '0;
      flag <= 1'b0;
      err  <= 1'b0;
    end else begin
      dout <= nxt_data;
      flag <= nxt_flag;
      err  <= nxt_err;
    end
  end

endmodule

// File: rtl/lane_inv_dec.sv
module lane_inv_dec #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         inv_en,
  input  logic         flag,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic flip;
  assign flip = inv_en & flag;

  always_ff @(posedge clk) begin
    if (rst || !in_valid) begin
      dout <= '0;
    end else begin
      dout <= flip ? ~din : din;
    end
  end

endmodule

// File: rtl/lane_inv_codec.sv
module lane_inv_codec #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_inv_en,
  input  logic             rd_inv_en,
  input  logic             tx_valid,
  input  logic [DW-1:0]    tx_data,
  input  logic [LANES-1:0] tx_mask,
  output logic             tx_bus_valid,
  output logic [DW-1:0]    tx_bus_data,
  output logic [LANES-1:0] tx_bus_flag,
  output logic [LANES-1:0] tx_mask_err,
  input  logic             rx_valid,
  input  logic [DW-1:0]    rx_bus_data,
  input  logic [LANES-1:0] rx_bus_flag,
  output logic             rx_out_valid,
  output logic [DW-1:0]    rx_out_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_bus_valid <= 1'b0;
      rx_out_valid <= 1'b0;
    end else begin
      tx_bus_valid <= tx_valid;
      rx_out_valid <= rx_valid;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_inv_enc #(.W(LANE_W)) u_enc (
      .clk      (clk),
      .rst      (rst),
      .in_valid (tx_valid),
      .inv_en   (wr_inv_en),
      .mask     (tx_mask[g]),
      .din      (tx_data[g*LANE_W +: LANE_W]),
      .dout     (tx_bus_data[g*LANE_W +: LANE_W]),
      .flag     (tx_bus_flag[g]),
      .err      (tx_mask_err[g])
    );

    lane_inv_dec #(.W(LANE_W)) u_dec (
      .clk      (clk),
      .rst      (rst),
      .in_valid (rx_valid),
      .inv_en   (rd_inv_en),
      .flag     (rx_bus_flag[g]),
      .din      (rx_bus_data[g*LANE_W +: LANE_W]),
      .dout     (rx_out_data[g*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/lane_inv_codec_chk.sv
module lane_inv_codec_chk #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_inv_en,
  input logic             rd_inv_en,
  input logic             tx_valid,
  input logic [DW-1:0]    tx_data,
  input logic [LANES-1:0] tx_mask,
  input logic             tx_bus_valid,
  input logic [DW-1:0]    tx_bus_data,
  input logic [LANES-1:0] tx_bus_flag,
  input logic [LANES-1:0] tx_mask_err,
  input logic             rx_valid,
  input logic [DW-1:0]    rx_bus_data,
  input logic [LANES-1:0] rx_bus_flag,
  input logic             rx_out_valid,
  input logic [DW-1:0]    rx_out_data
);

  AST_TX_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    tx_valid |=> tx_bus_valid); // R7
  AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> rx_out_valid); // R7
  AST_TX_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !tx_valid |=> (tx_bus_data == '0 && tx_bus_flag == '0 && tx_mask_err == '0)); // R7
  AST_PLAIN_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !wr_inv_en && tx_mask == '0) |=> (tx_bus_flag == '0 && tx_bus_data == $past(tx_data))); // R4
  AST_RX_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rd_inv_en) |=> rx_out_data == $past(rx_bus_data)); // R9

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    AST_FEW_LINES_HIGH: assert property (@(posedge clk) disable iff (rst)
      (tx_valid && wr_inv_en && !tx_mask[g]) |=>
        ($countones(tx_bus_data[g*LANE_W +: LANE_W]) <= LANE_W/2)); // R2
    AST_ERR_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
      tx_mask_err[g] |-> !tx_bus_flag[g]); // R6
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
      (tx_valid && !(wr_inv_en && tx_mask[g])) |=> !tx_mask_err[g]); // R6
  end

endmodule

bind lane_inv_codec lane_inv_codec_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/sim_lane_inv_codec.sv
module sim_lane_inv_codec;
  localparam int LANES = 2;
  localparam int LW    = 8;
  localparam int DW    = LANES * LW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_inv_en = 1'b0, rd_inv_en = 1'b0;
  logic tx_valid = 1'b0, rx_valid = 1'b0;
  logic [DW-1:0] tx_data = '0, rx_bus_data = '0;
  logic [LANES-1:0] tx_mask = '0, rx_bus_flag = '0;
  logic tx_bus_valid, rx_out_valid;
  logic [DW-1:0] tx_bus_data, rx_out_data;
  logic [LANES-1:0] tx_bus_flag, tx_mask_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [DW-1:0]    data;
    logic [LANES-1:0] flag;
    logic [LANES-1:0] err;
  } tx_exp_t;

  tx_exp_t       txq[$];
  string         txtag[$];
  logic [DW-1:0] rxq[$];
  string         rxtag[$];

  always #5 clk = ~clk;

  lane_inv_codec u0 (
    .clk(clk), .rst(rst), .wr_inv_en(wr_inv_en), .rd_inv_en(rd_inv_en),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_mask(tx_mask),
    .tx_bus_valid(tx_bus_valid), .tx_bus_data(tx_bus_data),
    .tx_bus_flag(tx_bus_flag), .tx_mask_err(tx_mask_err),
    .rx_valid(rx_valid), .rx_bus_data(rx_bus_data), .rx_bus_flag(rx_bus_flag),
    .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic tx_exp_t tx_model(input logic [DW-1:0] d, input logic [LANES-1:0] m, input logic en);
    tx_exp_t e;
    for (int l = 0; l < LANES; l++) begin
      logic [LW-1:0] b;
      b = d[l*LW +: LW];
      e.data[l*LW +: LW] = b;
      e.flag[l] = 1'b0;
      e.err[l]  = 1'b0;
      if (!en) e.flag[l] = m[l];
      else if (m[l]) e.err[l] = 1'b1;
      else if ($countones(b) >= 5) begin
        e.data[l*LW +: LW] = ~b;
        e.flag[l] = 1'b1;
      end
    end
    return e;
  endfunction

  // Drives one beat on each path in the same cycle (either may be idle).
  task automatic beat(input bit tv, input logic [DW-1:0] d, input logic [LANES-1:0] m, input logic wen,
                      input string ttag, input bit rv, input logic [DW-1:0] rd,
                      input logic [LANES-1:0] rf, input logic ren, input string rtag);
    @(negedge clk);
    tx_valid = tv; tx_data = d; tx_mask = m; wr_inv_en = wen;
    rx_valid = rv; rx_bus_data = rd; rx_bus_flag = rf; rd_inv_en = ren;
    if (tv) begin
      txq.push_back(tx_model(d, m, wen));
      txtag.push_back(ttag);
    end
    if (rv) begin
      logic [DW-1:0] r;
      for (int l = 0; l < LANES; l++)
        r[l*LW +: LW] = (ren && rf[l]) ? ~rd[l*LW +: LW] : rd[l*LW +: LW];
      rxq.push_back(r);
      rxtag.push_back(rtag);
    end
  endtask

  task automatic tx(input logic [DW-1:0] d, input logic [LANES-1:0] m, input logic wen, input string tag);
    beat(1'b1, d, m, wen, tag, 1'b0, '0, '0, 1'b0, "");
  endtask

  task automatic rx(input logic [DW-1:0] d, input logic [LANES-1:0] f, input logic ren, input string tag);
    beat(1'b0, '0, '0, 1'b0, "", 1'b1, d, f, ren, tag);
  endtask

  task automatic idle();
    beat(1'b0, '0, '0, 1'b0, "", 1'b0, '0, '0, 1'b0, "");
  endtask

  // Monitor: samples 2 ns after each rising edge.
  always @(posedge clk) begin
    #2;
    if (!rst && !done) begin
      if (tx_bus_valid) begin
        if (txq.size() == 0) check(1'b0, "R7 unexpected tx beat", 64'(tx_bus_data), 0);
        else begin
          tx_exp_t e, a;
          string t;
          e = txq.pop_front();
          t = txtag.pop_front();
          a = '{data: tx_bus_data, flag: tx_bus_flag, err: tx_mask_err};
          check(a == e, t, 64'(a), 64'(e));
        end
      end else begin
        check(tx_bus_data == '0 && tx_bus_flag == '0 && tx_mask_err == '0 && txq.size() == 0,
              "R7 idle tx", 64'({tx_bus_data, tx_bus_flag, tx_mask_err}), 0);
      end
      if (rx_out_valid) begin
        if (rxq.size() == 0) check(1'b0, "R7 unexpected rx beat", 64'(rx_out_data), 0);
        else begin
          logic [DW-1:0] e;
          string t;
          e = rxq.pop_front();
          t = rxtag.pop_front();
          check(rx_out_data == e, t, 64'(rx_out_data), 64'(e));
        end
      end else begin
        check(rx_out_data == '0 && rxq.size() == 0, "R7 idle rx", 64'(rx_out_data), 0);
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #6;
    check(tx_bus_valid == 0 && tx_bus_data == 0 && tx_bus_flag == 0 && tx_mask_err == 0
          && rx_out_valid == 0 && rx_out_data == 0, "R1 in reset", 64'({tx_bus_data, rx_out_data}), 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #2;
    check(tx_bus_valid == 0 && rx_out_valid == 0 && tx_bus_flag == 0, "R1 after reset",
          64'({tx_bus_valid, rx_out_valid, tx_bus_flag}), 0);

    // R2 threshold: 4 ones kept, 5 ones inverted, extremes
    tx(16'h1F0F, 2'b00, 1'b1, "R2 lane1 five ones, lane0 four ones");
    tx(16'h0F1F, 2'b00, 1'b1, "R2 lane0 five ones, lane1 four ones");
    tx(16'hFF00, 2'b00, 1'b1, "R2 all ones / all zeros");
    tx(16'hF7EF, 2'b00, 1'b1, "R2 seven ones both lanes");
    // R3 lane independence with one lane masked
    tx(16'hFFFF, 2'b01, 1'b1, "R3 lane1 inverted, lane0 masked R6");
    tx(16'hFFFF, 2'b10, 1'b0, "R3 lane1 masked, lane0 plain R5");
    // R4 / R5 write inversion off
    tx(16'hFFFF, 2'b00, 1'b0, "R4 heavy bytes pass plain");
    tx(16'hA5C3, 2'b11, 1'b0, "R5 both masked");
    // R6 masked with inversion on
    tx(16'hF8FE, 2'b11, 1'b1, "R6 both masked, heavy bytes not inverted");
    idle();
    // R8 / R9 receive
    rx(16'h00E0, 2'b01, 1'b1, "R8 lane0 flag restores");
    rx(16'h1234, 2'b11, 1'b1, "R8 both flags");
    rx(16'h1234, 2'b00, 1'b1, "R8 no flags");
    rx(16'h1234, 2'b11, 1'b0, "R9 flags ignored");
    rx(16'hFFFF, 2'b10, 1'b0, "R9 flag ignored lane1");
    idle();
    // R10 enables crossed, both paths active together
    beat(1'b1, 16'hFF1F, 2'b00, 1'b0, "R10 rd enable does not touch tx",
         1'b1, 16'h55AA, 2'b11, 1'b1, "R10 wr enable does not touch rx");
    beat(1'b1, 16'hFF1F, 2'b00, 1'b1, "R10 tx inverted with rd off",
         1'b1, 16'h55AA, 2'b11, 1'b0, "R10 rx plain with wr on");
    // R7 long back-to-back random traffic
    for (int i = 0; i < 400; i++) begin
      beat(1'b1, 16'($urandom), 2'($urandom), 1'($urandom), "R7 random tx burst",
           1'($urandom), 16'($urandom), 2'($urandom), 1'($urandom), "R7 random rx burst");
    end
    for (int i = 0; i < 100; i++) begin
      beat(1'($urandom), 16'($urandom), 2'($urandom), 1'($urandom), "R2 random gapped tx",
           1'($urandom), 16'($urandom), 2'($urandom), 1'($urandom), "R8 random gapped rx");
    end
    idle();
    idle();
    idle();
    check(txq.size() == 0 && rxq.size() == 0, "R7 all beats delivered",
          64'(txq.size() + rxq.size()), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule